// File: doc/BRIEF.md
# Shared Interrupt Router

This block takes a set of shared external interrupt inputs and forwards each one to the interrupt inputs of a small cluster of cores. By default it has 8 sources and 4 cores. Every source has its own settings: a destination core mask, a trigger type, a distribution mode and a mask bit. It also keeps a pending state. Software-side logic configures the block through a single-cycle command port. The block latches a mode word on request so that it can be read back. Nothing is forwarded until a one-time global enable command has been issued.

For each core there is one output line per source. In fixed distribution, a pending source drives the line of every core in its destination mask. In round-robin distribution, a pending source drives exactly one core. A per-source pointer then steps to the next core in the mask when the occurrence ends, so that successive occurrences rotate among the chosen cores.

Top module: `shared_irq_router`

## Requirements
- R1: After reset, every source is masked, the global enable is off and every output line is low. Every mode word reads 0 (level trigger, fixed distribution). Every destination mask holds all ones, and every round-robin pointer holds core 0.
- R2: No output line rises until a command with opcode 6 (enable) has been accepted. From then on the enable stays set until reset.
- R3: Opcode 4 (set mask) with cmd_data[0]=1 masks the named source, and with cmd_data[0]=0 unmasks it. All output lines of a masked source are low.
- R4: In fixed distribution, a source that is pending, unmasked and enabled drives the line of every core whose bit is set in its destination mask, all in the same cycle.
- R5: In round-robin distribution (field value 1), a delivered source drives only one core. That core is the first set bit of the destination mask at or after the pointer, searching upward with wrap-around. One cycle after delivery stops, the pointer moves to the first set destination bit after that core, with wrap-around.
- R6: Opcode 2 (set mode) stores cmd_data[1:0] as the distribution field and cmd_data[4] as the trigger type (1 = rising edge, 0 = active-high level). Bits [3:2] and [31:5] of the mode word always read 0. A distribution field of 0, 2 or 3 selects fixed distribution.
- R7: A level-triggered source is pending in the cycle after its input is sampled high and not pending in the cycle after it is sampled low.
- R8: An edge-triggered source becomes pending on a sampled rising edge of its input and stays pending until opcode 5 (acknowledge) names it. A rising edge in the same cycle as the acknowledge leaves it pending. An acknowledge has no effect on a level-triggered source.
- R9: Opcode 3 (read mode) loads rd_data with the named source's mode word on the next clock edge. rd_data holds that value until the next read.
- R10: Opcode 1 (set destination) stores cmd_data[NUM_CORE-1:0] as the destination mask, bit c for core c. A source with an empty mask drives no line.
- R11: The line for source s on core c is core_irq[c*NUM_SRC+s]. Commands with opcode 0 or 7, or with an index of NUM_SRC or more, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NUM_SRC | Shared interrupt inputs, active high |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_idx | input | $clog2(NUM_SRC) | Source the command names |
| cmd_data | input | 32 | Command payload |
| rd_data | output | 32 | Mode word latched by the last read command |
| core_irq | output | NUM_CORE*NUM_SRC | Per-core uplink lines, core-major |

## Verification
On every cycle, the in-line assertions check the following: no line is active before enable, and the enable never drops; an edge-pending source holds until it is acknowledged; a level source's pending state tracks the previous input sample; a round-robin source never drives two cores at once; and a read returns zeros in the reserved bits. Only the bench's scenarios can show the rest. That covers which core a round-robin sequence chooses and how it wraps, the exact line positions for a given destination mask, and how the modes 2 and 3 fall back to fixed delivery. It also covers the collision of an acknowledge with a new rising edge, and the fact that a read value holds across later commands. A behavioural model compares every output on every cycle.

// File: rtl/sir_pkg.sv
package sir_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_DEST   = 3'd1,
    OP_MODE   = 3'd2,
    OP_READ   = 3'd3,
    OP_MASK   = 3'd4,
    OP_ACK    = 3'd5,
    OP_ENABLE = 3'd6,
    OP_RSVD   = 3'd7
  } sir_op_e;

  localparam int unsigned DIST_LSB = 0;
  localparam int unsigned TRIG_BIT = 4;
  localparam logic [1:0]  DIST_RR  = 2'd1;
endpackage

// File: rtl/sir_channel.sv
module sir_channel #(
  parameter int unsigned NUM_CORE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                src,
  input  logic                we_dest,
  input  logic                we_mode,
  input  logic                we_mask,
  input  logic                ack,
  input  logic [NUM_CORE-1:0] dest_in,
  input  logic [1:0]          dist_in,
  input  logic                trig_in,
  input  logic                mask_in,
  input  logic                global_en,
  output logic [31:0]         mode_word,
  output logic [NUM_CORE-1:0] lines
);
  import sir_pkg::*;

  localparam int unsigned CW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;

  // first set bit of m at or after start, wrapping; start when m is empty
  function automatic logic [CW-1:0] first_from(input logic [NUM_CORE-1:0] m,
                                               input logic [CW-1:0] start);
    logic [CW-1:0] r;
    r = start;
    for (int k = NUM_CORE - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(start) + k) % NUM_CORE;
      if (m[idx]) r = CW'(idx);
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] wrap_inc(input logic [CW-1:0] v);
    return (int'(v) == NUM_CORE - 1) ? '0 : v + 1'b1;
  endfunction

  logic [NUM_CORE-1:0] dest_q;
  logic [1:0]          dist_q;
  logic                edge_q, mask_q, pend_q, prev_q, deliver_q;
  logic [CW-1:0]       ptr_q;

  logic          deliver, occ_end, rr_mode, rise;
  logic [CW-1:0] sel;

  assign rise    = src & ~prev_q;
  assign deliver = pend_q & ~mask_q & global_en;
  assign occ_end = deliver_q & ~deliver;
  assign rr_mode = (dist_q == DIST_RR);
  assign sel     = first_from(dest_q, ptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q    <= '1;
      dist_q    <= '0;
      edge_q    <= 1'b0;
      mask_q    <= 1'b1;
      pend_q    <= 1'b0;
      prev_q    <= 1'b0;
      deliver_q <= 1'b0;
      ptr_q     <= '0;
    end else begin
      prev_q    <= src;
      deliver_q <= deliver;
      if (edge_q) pend_q <= (pend_q & ~ack) | rise;
      else        pend_q <= src;
      if (occ_end) ptr_q <= first_from(dest_q, wrap_inc(sel));
      if (we_dest) dest_q <= dest_in;
      if (we_mode) begin
        dist_q <= dist_in;
        edge_q <= trig_in;
      end
      if (we_mask) mask_q <= mask_in;
    end
  end

  always_comb begin
    mode_word = '0;
    mode_word[DIST_LSB +: 2] = dist_q;
    mode_word[TRIG_BIT]      = edge_q;
  end

  always_comb begin
    lines = '0;
    if (deliver) begin
      if (rr_mode) lines[sel] = dest_q[sel];
      else         lines = dest_q;
    end
  end

  assert_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && pend_q && !ack) |=> pend_q)
    else $error("edge pending dropped without acknowledge");

  assert_level_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_q) |=> (pend_q == $past(src)))
    else $error("level pending does not track input");

  assert_rr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rr_mode |-> $onehot0(lines))
    else $error("round-robin drove more than one core");

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we_mask) && $past(mask_in)) |-> (lines == '0))
    else $error("masked source still drives a line");
endmodule

// File: rtl/shared_irq_router.sv
module shared_irq_router #(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned NUM_CORE = 4,
  localparam int unsigned IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           src_irq,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_op,
  input  logic [IW-1:0]                cmd_idx,
  input  logic [31:0]                  cmd_data,
  output logic [31:0]                  rd_data,
  output logic [NUM_CORE*NUM_SRC-1:0]  core_irq
);
  import sir_pkg::*;

  logic          en_q;
  logic [31:0]   rd_q;
  logic          idx_ok;
  sir_op_e       op;
  logic [31:0]   mode_words [NUM_SRC];
  logic [NUM_CORE-1:0] ch_lines [NUM_SRC];
  logic          unused_cmd;

  assign op         = sir_op_e'(cmd_op);
  assign idx_ok     = (32'(cmd_idx) < NUM_SRC);
  assign unused_cmd = ^cmd_data;

  function automatic logic hit(input sir_op_e o, input sir_op_e want,
                               input logic v, input logic ok);
    return v && ok && (o == want);
  endfunction

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic sel_here;
    assign sel_here = (32'(cmd_idx) == s);

    sir_channel #(.NUM_CORE(NUM_CORE)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (src_irq[s]),
      .we_dest   (sel_here && hit(op, OP_DEST, cmd_valid, idx_ok)),
      .we_mode   (sel_here && hit(op, OP_MODE, cmd_valid, idx_ok)),
      .we_mask   (sel_here && hit(op, OP_MASK, cmd_valid, idx_ok)),
      .ack       (sel_here && hit(op, OP_ACK,  cmd_valid, idx_ok)),
      .dest_in   (cmd_data[NUM_CORE-1:0]),
      .dist_in   (cmd_data[DIST_LSB +: 2]),
      .trig_in   (cmd_data[TRIG_BIT]),
      .mask_in   (cmd_data[0]),
      .global_en (en_q),
      .mode_word (mode_words[s]),
      .lines     (ch_lines[s])
    );

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      assign core_irq[c*NUM_SRC + s] = ch_lines[s][c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      rd_q <= '0;
    end else begin
      if (hit(op, OP_ENABLE, cmd_valid, 1'b1)) en_q <= 1'b1;
      if (hit(op, OP_READ, cmd_valid, idx_ok)) rd_q <= mode_words[cmd_idx];
    end
  end

  assign rd_data = rd_q;

  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q)
    else $error("global enable dropped");

  assert_no_fwd_before_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (core_irq == '0))
    else $error("line active before enable");

  assert_read_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_READ && idx_ok) |=> (rd_data[31:5] == '0 && rd_data[3:2] == '0))
    else $error("reserved mode bits read nonzero");
endmodule

// File: tb/shared_irq_router_tb_top.sv
module shared_irq_router_tb_top;
  localparam int NS = 8;
  localparam int NC = 4;
  localparam int IW = 3;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NS-1:0]    src_irq = '0;
  logic             cmd_valid = 1'b0;
  logic [2:0]       cmd_op = '0;
  logic [IW-1:0]    cmd_idx = '0;
  logic [31:0]      cmd_data = '0;
  logic [31:0]      rd_data;
  logic [NC*NS-1:0] core_irq;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] held;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_irq_router #(.NUM_SRC(NS), .NUM_CORE(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .rd_data(rd_data), .core_irq(core_irq)
  );

  // behavioural reference model
  int m_dest[NS], m_dist[NS], m_edge[NS], m_mask[NS];
  int m_pend[NS], m_prev[NS], m_ptr[NS], m_dq[NS];
  int m_en;
  logic [31:0] m_rd;

  function automatic int scan(int s, int start);
    for (int k = 0; k < NC; k++) begin
      int i;
      i = (start + k) % NC;
      if ((m_dest[s] >> i) & 1) return i;
    end
    return start;
  endfunction

  function automatic int live(int s);
    return (m_pend[s] != 0 && m_mask[s] == 0 && m_en != 0) ? 1 : 0;
  endfunction

  function automatic logic [NC*NS-1:0] expect_lines();
    logic [NC*NS-1:0] v;
    v = '0;
    for (int s = 0; s < NS; s++) begin
      if (live(s) != 0) begin
        for (int c = 0; c < NC; c++) begin
          int on;
          on = (m_dest[s] >> c) & 1;
          if (m_dist[s] == 1 && c != scan(s, m_ptr[s])) on = 0;
          v[c*NS + s] = (on != 0);
        end
      end
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        m_dest[s] = (1 << NC) - 1; m_dist[s] = 0; m_edge[s] = 0; m_mask[s] = 1;
        m_pend[s] = 0; m_prev[s] = 0; m_ptr[s] = 0; m_dq[s] = 0;
      end
      m_en = 0; m_rd = '0;
    end else begin
      for (int s = 0; s < NS; s++) begin
        int d;
        d = live(s);
        if (m_dq[s] != 0 && d == 0) m_ptr[s] = scan(s, (scan(s, m_ptr[s]) + 1) % NC);
        m_dq[s] = d;
      end
      for (int s = 0; s < NS; s++) begin
        int acked, rose;
        acked = (cmd_valid && cmd_op == 3'd5 && int'(cmd_idx) == s) ? 1 : 0;
        rose  = (src_irq[s] && m_prev[s] == 0) ? 1 : 0;
        if (m_edge[s] != 0) m_pend[s] = ((m_pend[s] != 0 && acked == 0) || rose != 0) ? 1 : 0;
        else                m_pend[s] = src_irq[s] ? 1 : 0;
        m_prev[s] = src_irq[s] ? 1 : 0;
      end
      if (cmd_valid) begin
        int i;
        i = int'(cmd_idx);
        case (cmd_op)
          3'd1: m_dest[i] = int'(cmd_data[NC-1:0]);
          3'd2: begin m_dist[i] = int'(cmd_data[1:0]); m_edge[i] = cmd_data[4] ? 1 : 0; end
          3'd3: m_rd = {27'd0, 1'(m_edge[i]), 2'b00, 2'(m_dist[i])};
          3'd4: m_mask[i] = cmd_data[0] ? 1 : 0;
          3'd6: m_en = 1;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison (R11 line layout and everything else)
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (core_irq !== expect_lines() || rd_data !== m_rd) begin
        miscompares++;
        $display("FAIL R11 model compare: lines %h rd %h, expected lines %h rd %h",
                 core_irq, rd_data, expect_lines(), m_rd);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic cmd(input logic [2:0] op, input int idx, input logic [31:0] data);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = IW'(idx); cmd_data = data;
    step();
    cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1'b1; step();
    // R1 reset state
    check("R1 lines after reset", core_irq, 32'h0);
    check("R1 rd after reset", rd_data, 32'h0);
    cmd(3'd3, 2, 32'h0);
    check("R1 R9 mode word after reset", rd_data, 32'h0);

    // R2 nothing before enable
    cmd(3'd4, 0, 32'h0);
    src_irq[0] = 1'b1; step(); step();
    check("R2 no line before enable", core_irq, 32'h0);
    cmd(3'd6, 0, 32'h0);
    check("R4 R11 fixed to all cores", core_irq, 32'h01010101);

    // R7 level tracking
    src_irq[0] = 1'b0; step();
    check("R7 level follows low", core_irq, 32'h0);
    src_irq[0] = 1'b1; step();
    check("R7 level follows high", core_irq, 32'h01010101);

    // R3 mask
    cmd(3'd4, 0, 32'h1);
    check("R3 masked source quiet", core_irq, 32'h0);
    cmd(3'd4, 0, 32'h0);
    check("R3 unmask restores", core_irq, 32'h01010101);

    // R10 destination
    cmd(3'd1, 0, 32'h5);
    check("R10 dest 0101", core_irq, 32'h00010001);
    cmd(3'd5, 0, 32'h0);
    check("R8 ack ignored on level source", core_irq, 32'h00010001);
    cmd(3'd1, 0, 32'h0);
    check("R10 empty dest", core_irq, 32'h0);
    src_irq[0] = 1'b0; step();

    // R6 mode word
    cmd(3'd2, 3, 32'hFFFFFFFF);
    cmd(3'd3, 3, 32'h0);
    check("R6 reserved bits read zero", rd_data, 32'h00000013);
    cmd(3'd2, 1, 32'h10);
    cmd(3'd3, 1, 32'h0);
    check("R6 R9 edge mode word", rd_data, 32'h00000010);
    held = rd_data;

    // R8 edge latch
    cmd(3'd4, 1, 32'h0);
    src_irq[1] = 1'b1; step(); src_irq[1] = 1'b0; step(); step(); step();
    check("R8 edge pending held", core_irq, 32'h02020202);
    check("R9 read value held", rd_data, held);
    cmd(3'd5, 1, 32'h0);
    check("R8 ack clears", core_irq, 32'h0);
    src_irq[1] = 1'b1;
    cmd(3'd5, 1, 32'h0);
    check("R8 rise beats ack", core_irq, 32'h02020202);
    src_irq[1] = 1'b0;
    cmd(3'd5, 1, 32'h0);

    // R5 round robin over cores 0,1,3
    cmd(3'd2, 2, 32'h1);
    cmd(3'd1, 2, 32'hB);
    cmd(3'd4, 2, 32'h0);
    src_irq[2] = 1'b1; step();
    check("R5 rr first core0", core_irq, 32'h00000004);
    src_irq[2] = 1'b0; step(); src_irq[2] = 1'b1; step();
    check("R5 rr next core1", core_irq, 32'h00000400);
    src_irq[2] = 1'b0; step(); src_irq[2] = 1'b1; step();
    check("R5 rr skip to core3", core_irq, 32'h04000000);
    src_irq[2] = 1'b0; step(); src_irq[2] = 1'b1; step();
    check("R5 rr wraps to core0", core_irq, 32'h00000004);
    src_irq[2] = 1'b0; step();

    // R6 field 3 behaves as fixed
    cmd(3'd2, 2, 32'h3);
    src_irq[2] = 1'b1; step();
    check("R6 field 3 is fixed", core_irq, 32'h04000404);

    // R11 reserved opcode changes nothing
    cmd(3'd7, 2, 32'hFFFFFFFF);
    cmd(3'd0, 2, 32'hFFFFFFFF);
    check("R11 ignored opcodes", core_irq, 32'h04000404);
    src_irq[2] = 1'b0; step(); step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule